// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a two-wire serial bus, placed in front of a 2048-byte array held in a register file. The system clock oversamples both bus lines. On each SCL high phase, the block looks for SDA edges that mark a start or a stop. Bits are shifted in and out during the SCL low phases. The block drives SDA through a single drive-low enable, which models an open-drain pad.

A transaction opens with a slave byte. This byte carries a fixed high bit, three device-select bits checked against strap inputs (the middle one compared inverted), three high array-address bits, and the read/write flag. A write transaction continues with a word address, then up to sixteen data bytes. The data bytes collect in a page buffer and reach the array only when the master sends a stop. After that, the block ignores the bus for a timed interval that stands in for the nonvolatile write. A read transaction streams bytes from an address counter until the master withholds its acknowledge.

Top module: `twi_eeprom_slave`

## Requirements
- R1: While reset is held and right after it is released, the SDA drive-low enable is 0 and the bus line floats high.
- R2: The slave answers nothing until it sees a start (SDA falling while SCL is high). A stop (SDA rising while SCL is high) in the middle of a byte returns it to idle, and any bits clocked after that without a new start draw no acknowledge.
- R3: A slave byte is accepted only when bit 7 is 1 and bits 6, 5, 4 equal strap 2, the inverse of strap 1, and strap 0. Any other slave byte gets no acknowledge, and every further byte up to the next start also gets none.
- R4: Bits 3..1 of the slave byte supply address bits 10..8, and the word address byte supplies bits 7..0. Bit 0 of the slave byte selects read (1) or write (0). A one-byte write followed by a read of the same address returns the written byte.
- R5: The slave pulls SDA low during the ninth SCL clock after an accepted slave byte. In a write, it does the same after the word address and after every data byte.
- R6: Written bytes reach the array only at a stop. If a start arrives before the stop, the pending bytes are discarded, the array keeps its contents, and no busy interval follows.
- R7: After a stop that commits data, the slave gives no acknowledge for BUSY_CLKS system clocks. Once that interval ends, it acknowledges a matching slave byte again.
- R8: During a write, the low 4 address bits step up by one after each data byte and wrap inside the 16-byte page, while bits 10..4 do not change.
- R9: During a read, the address advances by one after each byte sent and wraps from 2047 to 0.
- R10: When the master leaves SDA high in the acknowledge slot of a read, the slave stops driving SDA until the next start or stop.
- R11: A read that has no word address before it starts at address bits 10..8 from its slave byte and bits 7..0 from the current counter.
- R12: The slave sends read data MSB first and changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Resolved level of the serial data line |
| dev_sel_i | input | 3 | Device-select straps; bit 1 is compared inverted |
| sda_low_o | output | 1 | Drive-low enable for the open-drain SDA pad |

## Verification
Each bus line passes through two synchronizer flops and one edge register, and the drive register adds one more. So the acknowledge and each read bit appear on SDA about three system clocks after the SCL fall that opens their slot. The bench holds every SCL half period for eight system clocks. It reads acknowledges and data at the middle of the high phase, and reads each data bit a second time at the end of that phase to confirm it did not move. A commit counts BUSY_CLKS clocks from the stop that caused it. The bench probes the silent window straight after that stop, then waits out the full interval before it tries again.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int PAGE_W    = 4,
  parameter int BUSY_CLKS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  output logic       sda_low_o
);
  localparam int WORD_W = 8;
  localparam int ADDR_W = WORD_W + 3;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(BUSY_CLKS + 1);
  localparam logic [PAGE_W-1:0] PG_ONE = 1;
  localparam logic [ADDR_W-1:0] AD_ONE = 1;
  localparam logic [CNT_W-1:0]  BUSY_LOAD = CNT_W'(BUSY_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WORD, S_WDATA, S_RDATA, S_WAIT, S_BUSY} st_t;

  logic [2:0]        scl_s, sda_s;
  st_t               state;
  logic [3:0]        bitcnt;
  logic              in_ack, macked, drv;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   pvalid;
  logic [CNT_W-1:0]  busy_cnt;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];

  wire scl_q = scl_s[1];
  wire scl_p = scl_s[2];
  wire sda_q = sda_s[1];
  wire sda_p = sda_s[2];

  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire scl_rise  = scl_q & ~scl_p;
  wire scl_fall  = ~scl_q & scl_p;
  wire byte_done = scl_fall & (bitcnt == 4'd8) & ~in_ack;
  wire addr_hit  = shreg[7] & (shreg[6:4] == {dev_sel_i[2], ~dev_sel_i[1], dev_sel_i[0]});
  wire wr_byte   = (state == S_WDATA) & byte_done & ~start_det & ~stop_det;
  wire commit    = (state != S_BUSY) & stop_det & (|pvalid);
  wire [7:0] rd_byte = mem[ptr];

  wire st_idle = (state == S_IDLE);
  wire st_busy = (state == S_BUSY);
  wire st_wait = (state == S_WAIT);

  assign sda_low_o = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[ptr[PAGE_W-1:0]] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pvalid[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= 4'd0;
      in_ack   <= 1'b0;
      macked   <= 1'b0;
      drv      <= 1'b0;
      shreg    <= 8'd0;
      ptr      <= '0;
      pvalid   <= '0;
      busy_cnt <= '0;
    end else if (state == S_BUSY) begin
      if (busy_cnt == '0) state <= S_IDLE;
      else busy_cnt <= busy_cnt - 1'b1;
    end else if (start_det) begin
      state  <= S_ADDR;
      bitcnt <= 4'd0;
      in_ack <= 1'b0;
      drv    <= 1'b0;
      pvalid <= '0;
    end else if (stop_det) begin
      drv    <= 1'b0;
      in_ack <= 1'b0;
      bitcnt <= 4'd0;
      pvalid <= '0;
      if (|pvalid) begin
        state    <= S_BUSY;
        busy_cnt <= BUSY_LOAD;
      end else begin
        state <= S_IDLE;
      end
    end else begin
      case (state)
        S_ADDR, S_WORD, S_WDATA: begin
          if (scl_rise && !in_ack && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= 4'd0;
            drv    <= 1'b0;
          end else if (byte_done) begin
            if (state == S_ADDR) begin
              if (addr_hit) begin
                drv    <= 1'b1;
                in_ack <= 1'b1;
                ptr    <= {shreg[3:1], ptr[WORD_W-1:0]};
                macked <= 1'b1;
                state  <= shreg[0] ? S_RDATA : S_WORD;
              end else begin
                drv    <= 1'b0;
                bitcnt <= 4'd0;
                state  <= S_IDLE;
              end
            end else if (state == S_WORD) begin
              ptr    <= {ptr[ADDR_W-1:WORD_W], shreg};
              drv    <= 1'b1;
              in_ack <= 1'b1;
              state  <= S_WDATA;
            end else begin
              pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
              ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PG_ONE};
              drv    <= 1'b1;
              in_ack <= 1'b1;
            end
          end
        end
        S_RDATA: begin
          if (scl_rise && in_ack) begin
            macked <= ~sda_q;
          end else if (scl_fall && in_ack) begin
            in_ack <= 1'b0;
            if (macked) begin
              shreg  <= rd_byte;
              drv    <= ~rd_byte[7];
              ptr    <= ptr + AD_ONE;
              bitcnt <= 4'd0;
            end else begin
              drv   <= 1'b0;
              state <= S_WAIT;
            end
          end else if (scl_rise && bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drv    <= 1'b0;
              in_ack <= 1'b1;
            end else if (bitcnt != 4'd0) begin
              shreg <= {shreg[6:0], 1'b0};
              drv   <= ~shreg[6];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_q,
  input logic             sda_low,
  input logic             st_idle,
  input logic             st_busy,
  input logic             st_wait,
  input logic             in_ack,
  input logic [3:0]       bitcnt,
  input logic [CNT_W-1:0] busy_cnt
);
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_low);

  assert_busy_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> !sda_low);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy && busy_cnt != '0) |=> st_busy);

  assert_nack_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_wait |-> !sda_low);

  assert_ack_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> (bitcnt == 4'd8));

  assert_drive_on_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !$past(scl_q));
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_q    (scl_q),
  .sda_low  (sda_low_o),
  .st_idle  (st_idle),
  .st_busy  (st_busy),
  .st_wait  (st_wait),
  .in_ack   (in_ack),
  .bitcnt   (bitcnt),
  .busy_cnt (busy_cnt)
);

// File: tb/tb_twi_eeprom_slave.sv
module tb_twi_eeprom_slave;
  localparam int BUSY = 600;
  localparam int H    = 8;
  localparam logic [2:0] SEL = 3'b010;
  localparam logic [18:0] VEC [8] = '{
    {11'h000, 8'hA5}, {11'h123, 8'h3C}, {11'h2FF, 8'h01}, {11'h400, 8'hFF},
    {11'h555, 8'h00}, {11'h6AB, 8'h7E}, {11'h7F0, 8'hC3}, {11'h0E7, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic dut_low;
  wire  sda_line = ~(m_low | dut_low);
  int   checks = 0, errors = 0;
  bit   done = 1'b0, stable_ok = 1'b1;

  always #4 clk = ~clk;

  twi_eeprom_slave #(.PAGE_W(4), .BUSY_CLKS(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_sel_i(SEL), .sda_low_o(dut_low)
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(logic [2:0] hi, logic rw, logic s1ok = 1'b1);
    return {1'b1, SEL[2], s1ok ? ~SEL[1] : SEL[1], SEL[0], hi, rw};
  endfunction

  task automatic bus_start();
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H); m_low = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(H); scl = 1'b1; tick(H); m_low = 1'b0; tick(H);
  endtask

  task automatic clock_bit(logic b);
    if (scl) begin scl = 1'b0; tick(2); end
    m_low = ~b; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H/2);
    ack = ~sda_line;
    tick(H/2); scl = 1'b0; tick(2);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    logic v, v2;
    b = 8'h00;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(H); scl = 1'b1; tick(H/2); v = sda_line;
      tick(H/2 - 1); v2 = sda_line; tick(1);
      if (v != v2) stable_ok = 1'b0;
      scl = 1'b0; tick(2);
      b = {b[6:0], v};
    end
    m_low = mack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2); m_low = 1'b0;
  endtask

  task automatic wr1(logic [10:0] a, logic [7:0] d, string req);
    logic ack;
    bus_start();
    send_byte(devb(a[10:8], 1'b0), ack); chk(ack, "R5 slave byte", ack, 1);
    send_byte(a[7:0], ack);              chk(ack, "R5 word address", ack, 1);
    send_byte(d, ack);                   chk(ack, req, ack, 1);
    bus_stop();
    tick(BUSY + 20);
  endtask

  task automatic rd_rand(logic [10:0] a, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(devb(a[10:8], 1'b0), ack); chk(ack, "R5 slave byte", ack, 1);
    send_byte(a[7:0], ack);              chk(ack, "R5 word address", ack, 1);
    bus_start();
    send_byte(devb(a[10:8], 1'b1), ack); chk(ack, "R4 read slave byte", ack, 1);
    read_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d, d2;

    tick(5);
    chk(dut_low == 1'b0, "R1 in reset", dut_low, 0);
    rst_n = 1'b1; tick(5);
    chk(dut_low == 1'b0 && sda_line == 1'b1, "R1 after reset", dut_low, 0);

    // R2: no start, then stop mid-byte
    send_byte(devb(3'd0, 1'b0), ack);
    chk(!ack, "R2 no start", ack, 0);
    bus_start();
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b0); clock_bit(1'b0);
    bus_stop();
    send_byte(devb(3'd0, 1'b0), ack);
    chk(!ack, "R2 after mid-byte stop", ack, 0);

    // R3: address mismatch
    bus_start();
    send_byte(devb(3'd0, 1'b0, 1'b0), ack);
    chk(!ack, "R3 strap 1 not inverted", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 follow-on byte", ack, 0);
    bus_start();
    send_byte({1'b0, devb(3'd0, 1'b0)}[7:0] & 8'h7F, ack);
    chk(!ack, "R3 msb zero", ack, 0);
    bus_stop();

    // R4 vector table
    foreach (VEC[i]) wr1(VEC[i][18:8], VEC[i][7:0], "R5 data byte");
    foreach (VEC[i]) begin
      rd_rand(VEC[i][18:8], d);
      chk(d == VEC[i][7:0], "R4 byte write readback", d, VEC[i][7:0]);
    end

    // R6: start before stop discards
    bus_start();
    send_byte(devb(3'd1, 1'b0), ack);
    send_byte(8'h23, ack);
    send_byte(8'h99, ack);
    chk(ack, "R6 data acked", ack, 1);
    bus_start();
    bus_stop();
    rd_rand(11'h123, d);
    chk(d == 8'h3C, "R6 discarded data", d, 8'h3C);

    // R7: busy window
    bus_start();
    send_byte(devb(3'd2, 1'b0), ack);
    send_byte(8'h10, ack);
    send_byte(8'h6D, ack);
    bus_stop();
    bus_start();
    send_byte(devb(3'd2, 1'b0), ack);
    chk(!ack, "R7 busy no ack", ack, 0);
    bus_stop();
    tick(BUSY);
    bus_start();
    send_byte(devb(3'd2, 1'b0), ack);
    chk(ack, "R7 ack after busy", ack, 1);
    bus_stop();
    rd_rand(11'h210, d);
    chk(d == 8'h6D, "R6 committed at stop", d, 8'h6D);

    // R8: page wrap
    bus_start();
    send_byte(devb(3'd3, 1'b0), ack);
    send_byte(8'h5E, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    send_byte(8'h33, ack); send_byte(8'h44, ack);
    chk(ack, "R8 page bytes acked", ack, 1);
    bus_stop();
    tick(BUSY + 20);
    rd_rand(11'h35E, d);  chk(d == 8'h11, "R8 first byte", d, 8'h11);
    rd_rand(11'h35F, d);  chk(d == 8'h22, "R8 page end", d, 8'h22);
    rd_rand(11'h350, d);  chk(d == 8'h33, "R8 wrapped to page start", d, 8'h33);
    rd_rand(11'h351, d);  chk(d == 8'h44, "R8 after wrap", d, 8'h44);
    rd_rand(11'h360, d);  chk(d != 8'h55, "R8 next page untouched", d, 0);

    // R9 + R11: sequential read wraps, then current address read
    wr1(11'h7FF, 8'hD1, "R9 setup");
    wr1(11'h000, 8'hE2, "R9 setup");
    wr1(11'h001, 8'h4B, "R11 setup");
    bus_start();
    send_byte(devb(3'd7, 1'b0), ack);
    send_byte(8'hFF, ack);
    bus_start();
    send_byte(devb(3'd7, 1'b1), ack);
    read_byte(d, 1'b1);
    read_byte(d2, 1'b0);
    bus_stop();
    chk(d == 8'hD1, "R9 last address", d, 8'hD1);
    chk(d2 == 8'hE2, "R9 wrap to zero", d2, 8'hE2);
    bus_start();
    send_byte(devb(3'd0, 1'b1), ack);
    chk(ack, "R11 current read acked", ack, 1);
    read_byte(d, 1'b0);
    bus_stop();
    chk(d == 8'h4B, "R11 counter address", d, 8'h4B);

    // R10: master nack releases bus
    bus_start();
    send_byte(devb(3'd1, 1'b0), ack);
    send_byte(8'h23, ack);
    bus_start();
    send_byte(devb(3'd1, 1'b1), ack);
    read_byte(d, 1'b0);
    chk(d == 8'h3C, "R10 byte before nack", d, 8'h3C);
    read_byte(d2, 1'b0);
    chk(d2 == 8'hFF, "R10 released after nack", d2, 8'hFF);
    bus_stop();

    chk(stable_ok, "R12 drive stable while SCL high", stable_ok, 1);
    chk(dut_low == 1'b0, "R2 idle at end", dut_low, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule